// File: doc/BRIEF.md
# Packet Endianness and Address Fixup Shim

This block sits in a 64-bit valid/ready packet stream, between the logical layer of a serial packet link and the user logic behind it. A packet is one header beat followed by zero or more data beats. The header carries a 34-bit byte address in bits [33:0] and a transfer-size code in bits [51:48]. When the remote peer builds its addresses and payload in the opposite word order, the shim makes two corrections. For a 4-byte access it inverts address bit 2 in the header. On every data beat it reverses all eight bytes of the 64-bit word.

The shim holds one register stage. It moves one beat per clock and holds its output stable under backpressure. Packet boundaries, the last flag and every other header field pass through unchanged. A bypass input turns both corrections off for peers that need none. Bypass is sampled when the header is accepted and then applies to the whole packet.

Top module: `pkt_fix_shim`

## Requirements
- R1: A header beat whose size code in bits [51:48] is 3 (a 4-byte access) leaves with address bit 2 inverted, for example 0x0 to 0x4, 0x4 to 0x0 and 0x134 to 0x130, when bypass was low at its acceptance.
- R2: On a header beat, every bit other than bit 2 leaves unchanged. This includes address bits [33:32], the size code and all bits above the address.
- R3: A header beat whose size code is not 3 leaves completely unchanged.
- R4: Each data beat leaves byte-reversed across the full 64 bits: input byte i (bits 8i+7..8i) becomes output byte 7-i. For example, 0x0102030405060708 becomes 0x0807060504030201.
- R5: A header beat is never byte-reversed.
- R6: With bypass high at header acceptance, both the header and the data beats of that packet pass unchanged. A change of bypass after the header has no effect until the next header.
- R7: The last flag passes through with its beat. The beat after a last beat is treated as a header, and this includes a header-only packet.
- R8: While output valid is high and output ready is low, the output data, last flag and valid stay stable and input ready is low.
- R9: With output ready held high, the shim accepts and presents one beat per clock, with a latency of one clock.
- R10: A synchronous active-low reset clears output valid and returns the shim to expecting a header, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bypassIn | input | 1 | Disables both corrections; sampled with each header |
| inData | input | 64 | Incoming beat |
| inValid | input | 1 | Incoming beat valid |
| inLast | input | 1 | Incoming beat ends its packet |
| inReady | output | 1 | Shim can take a beat |
| outData | output | 64 | Corrected beat |
| outValid | output | 1 | Outgoing beat valid |
| outLast | output | 1 | Outgoing beat ends its packet |
| outReady | input | 1 | Downstream takes the beat |

## Verification
Headers are sent with size code 3 at addresses 0x0, 0x4 and 0x134, and with the extended bits [33:32] and the upper header nibbles set. This separates a flip of bit 2 alone from a flip that also touches neighbouring bits. Headers with size codes 7 and 1 show that only the 4-byte code triggers the flip. Data words with distinct bytes in every lane tell a full 64-bit reversal apart from a swap within each 32-bit half. Bypass is toggled mid-packet, and reset is applied mid-packet, to show which beat the shim takes for a header.

// File: rtl/pkt_fix_pkg.sv
package pkt_fix_pkg;

  typedef enum logic {
    ST_HDR  = 1'b0,
    ST_DATA = 1'b1
  } beatState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // beat accepted this cycle
    logic drain;      // downstream took the held beat
    logic isHeader;   // the beat at the input is a header
    logic fixAddr;    // invert the word-select address bit
    logic swapBytes;  // reverse bytes across the word
  } fixStrobes_t;

endpackage

// File: rtl/pkt_fix_ctrl.sv
module pkt_fix_ctrl
  import pkt_fix_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int WORD_CODE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassIn,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [SIZE_W-1:0] sizeField,
  input  logic              outValidQ,
  input  logic              outReady,
  output logic              inReady,
  output fixStrobes_t       strobes
);

  localparam logic [SIZE_W-1:0] WORD_VAL = SIZE_W'(WORD_CODE);

  beatState_t state;
  logic       bypassHeld;
  logic       effBypass;
  logic       isHeader;
  logic       accept;

  assign inReady   = !outValidQ || outReady;
  assign accept    = inValid && inReady;
  assign isHeader  = (state == ST_HDR);
  assign effBypass = isHeader ? bypassIn : bypassHeld;

  always_comb begin
    strobes.load      = accept;
    strobes.drain     = outReady;
    strobes.isHeader  = isHeader;
    strobes.fixAddr   = isHeader && !effBypass && (sizeField == WORD_VAL);
    strobes.swapBytes = !isHeader && !effBypass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_HDR;
      bypassHeld <= 1'b0;
    end else if (accept) begin
      if (isHeader) bypassHeld <= bypassIn;
      state <= inLast ? ST_HDR : ST_DATA;
    end
  end

  // R7
  last_to_header_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inLast) |=> (state == ST_HDR));

  // R6
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !isHeader) |=> (bypassHeld == $past(bypassHeld)));

  // R10
  reset_header_chk: assert property (@(posedge clk)
    !rstN |=> (state == ST_HDR));

endmodule

// File: rtl/pkt_fix_datapath.sv
module pkt_fix_datapath
  import pkt_fix_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 34,
  parameter int FLIP_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  fixStrobes_t       strobes,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outValid
);

  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] FLIP_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << FLIP_BIT;

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] nextData;

  for (genvar i = 0; i < NBYTES; i++) begin : g_rev
    assign swapped[8*i +: 8] = inData[8*(NBYTES-1-i) +: 8];
  end

  always_comb begin
    if (strobes.swapBytes)     nextData = swapped;
    else if (strobes.fixAddr)  nextData = inData ^ FLIP_MASK;
    else                       nextData = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
    end else if (strobes.load) begin
      outValid <= 1'b1;
      outLast  <= inLast;
      outData  <= nextData;
    end else if (strobes.drain) begin
      outValid <= 1'b0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !strobes.drain) |=>
      (outValid && $stable(outData) && $stable(outLast)));

  // R1
  addr_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.fixAddr) |=> (outData[FLIP_BIT] != $past(inData[FLIP_BIT])));

  // R2
  addr_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.isHeader) |=>
      (outData[DATA_W-1:FLIP_BIT+1] == $past(inData[DATA_W-1:FLIP_BIT+1]) &&
       outData[FLIP_BIT-1:0] == $past(inData[FLIP_BIT-1:0]) &&
       outData[ADDR_W-1:ADDR_W-2] == $past(inData[ADDR_W-1:ADDR_W-2])));

  // R4
  byte_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.swapBytes) |=>
      (outData[7:0] == $past(inData[DATA_W-1:DATA_W-8]) &&
       outData[DATA_W-1:DATA_W-8] == $past(inData[7:0])));

  // R10
  reset_valid_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: rtl/pkt_fix_shim.sv
module pkt_fix_shim
  import pkt_fix_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 34,
  parameter int FLIP_BIT  = 2,
  parameter int SIZE_LSB  = 48,
  parameter int SIZE_W    = 4,
  parameter int WORD_CODE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassIn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady
);

  fixStrobes_t strobes;

  pkt_fix_ctrl #(
    .SIZE_W    (SIZE_W),
    .WORD_CODE (WORD_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bypassIn  (bypassIn),
    .inValid   (inValid),
    .inLast    (inLast),
    .sizeField (inData[SIZE_LSB +: SIZE_W]),
    .outValidQ (outValid),
    .outReady  (outReady),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  pkt_fix_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .FLIP_BIT (FLIP_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inLast   (inLast),
    .strobes  (strobes),
    .outData  (outData),
    .outLast  (outLast),
    .outValid (outValid)
  );

endmodule

// File: tb/pkt_fix_shim_tb.sv
module pkt_fix_shim_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        bypassIn;
  logic [63:0] inData;
  logic        inValid;
  logic        inLast;
  logic        inReady;
  logic [63:0] outData;
  logic        outValid;
  logic        outLast;
  logic        outReady;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  pkt_fix_shim u_dut (
    .clk(clk), .rstN(rstN), .bypassIn(bypassIn),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outReady(outReady)
  );

  typedef struct packed {
    logic        byp;
    logic [63:0] hdrIn;
    logic [63:0] hdrExp;
    logic [63:0] dat;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 64'h0003_0000_0000_0000, 64'h0003_0000_0000_0004, 64'h0102_0304_0506_0708},
    '{1'b0, 64'h0003_0000_0000_0004, 64'h0003_0000_0000_0000, 64'h1122_3344_5566_7788},
    '{1'b0, 64'h0003_0000_0000_0134, 64'h0003_0000_0000_0130, 64'hDEAD_BEEF_0BAD_F00D},
    '{1'b0, 64'hABC3_0003_0000_0134, 64'hABC3_0003_0000_0130, 64'h0011_2233_4455_6677},
    '{1'b0, 64'h0007_0000_0000_0134, 64'h0007_0000_0000_0134, 64'h8899_AABB_CCDD_EEFF},
    '{1'b1, 64'h0003_0000_0000_0000, 64'h0003_0000_0000_0000, 64'h0102_0304_0506_0708},
    '{1'b0, 64'h1231_0002_FFFF_FFF4, 64'h1231_0002_FFFF_FFF4, 64'hF0E1_D2C3_B4A5_9687}
  };

  function automatic logic [63:0] rev64(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a beat after the edge, let it be taken at the next edge, sample 1 ns later
  task automatic beat(input logic [63:0] d, input logic last, input logic byp);
    inData = d; inLast = last; bypassIn = byp; inValid = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idle();
    inValid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    rstN = 1'b0; bypassIn = 1'b0; inData = '0; inValid = 1'b0; inLast = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk); #1;
    // R10 reset state
    check("R10 valid in reset", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    idle();

    // table walk: header + one data beat per packet
    for (int k = 0; k < 7; k++) begin
      beat(VECS[k].hdrIn, 1'b0, VECS[k].byp);
      check("R1/R2/R3/R5 header", outData, VECS[k].hdrExp);
      check("R9 header valid", {63'd0, outValid}, 64'd1);
      beat(VECS[k].dat, 1'b1, VECS[k].byp);
      check(VECS[k].byp ? "R6 bypass data" : "R4 data reversal", outData,
            VECS[k].byp ? VECS[k].dat : rev64(VECS[k].dat));
      check("R7 last flag", {63'd0, outLast}, 64'd1);
      idle();
      check("R9 drained", {63'd0, outValid}, 64'd0);
    end

    // R4 literal and not a half-word swap
    beat(64'h0003_0000_0000_0010, 1'b0, 1'b0);
    check("R1 header 0x10", outData, 64'h0003_0000_0000_0014);
    beat(64'h0102_0304_0506_0708, 1'b0, 1'b1);  // R6 bypass change mid-packet ignored
    check("R4 literal reversal", outData, 64'h0807_0605_0403_0201);
    check("R7 mid-packet last low", {63'd0, outLast}, 64'd0);
    beat(64'hA1A2_A3A4_B1B2_B3B4, 1'b1, 1'b1);
    check("R6 mid-packet bypass ignored", outData, 64'hB4B3_B2B1_A4A3_A2A1);
    // bypass packet, bypass dropped mid-packet
    beat(64'h0003_0000_0000_0004, 1'b0, 1'b1);
    check("R6 bypass header", outData, 64'h0003_0000_0000_0004);
    beat(64'h0102_0304_0506_0708, 1'b1, 1'b0);
    check("R6 bypass held for data", outData, 64'h0102_0304_0506_0708);

    // R7 header-only packets back to back
    beat(64'h0003_0000_0000_0000, 1'b1, 1'b0);
    check("R7 header-only 1", outData, 64'h0003_0000_0000_0004);
    beat(64'h0003_0000_0000_0134, 1'b1, 1'b0);
    check("R7 header-only 2", outData, 64'h0003_0000_0000_0130);
    idle();

    // R8 backpressure
    outReady = 1'b0;
    beat(64'h0003_0000_0000_0004, 1'b0, 1'b0);
    inData = 64'h0102_0304_0506_0708; inLast = 1'b1; inValid = 1'b1;
    #0.5;
    check("R8 inReady low", {63'd0, inReady}, 64'd0);
    for (int w = 0; w < 3; w++) begin
      @(posedge clk); #1;
      check("R8 held data", outData, 64'h0003_0000_0000_0000);
      check("R8 held valid", {63'd0, outValid}, 64'd1);
      check("R8 held last", {63'd0, outLast}, 64'd0);
    end
    outReady = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0;
    check("R8 released data", outData, 64'h0807_0605_0403_0201);
    check("R8 released last", {63'd0, outLast}, 64'd1);
    idle();

    // R10 reset mid-packet
    beat(64'h0007_0000_0000_0000, 1'b0, 1'b0);
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R10 valid cleared", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    beat(64'h0003_0000_0000_0000, 1'b1, 1'b0);
    check("R10 back to header", outData, 64'h0003_0000_0000_0004);
    idle();

    finish();
  end

endmodule